// File: doc/BRIEF.md
# Input Sync Timing Error Monitor

This block sits on the pixel-clock side of a video capture path. It watches the incoming horizontal sync, vertical sync and field signals and measures each line and each frame. A pixel counter restarts at every horizontal leading edge. A line counter restarts at every vertical leading edge and advances on horizontal leading edges.

When a sync leading edge arrives while the matching counter is still inside its programmed active window, the block reports a timing error. Horizontal and vertical errors are reported separately. It also reports every sync leading edge and every change of the field signal.

All reports are single-clock pulses, meant to be OR-ed into sticky status bits elsewhere. The window bounds are static configuration inputs. The asynchronous inputs pass through a two-stage synchronizer before any edge is detected.

Top module: `sync_err_mon`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, all four event outputs are 0. Reset clears the synchronizer history to 0, clears both counters, and disarms error reporting.
- R2: A leading (rising) edge of hsync_in or vsync_in raises sync_seen_o for exactly one clock. A level first captured at rising clock edge k shows on the outputs after edge k+2, and the same latency applies to every event output. Simultaneous horizontal and vertical edges give a single pulse.
- R3: Every change of field_in, rising or falling, raises odd_tgl_o for one clock. A field change does not raise sync_seen_o.
- R4: The pixel count checked at a horizontal leading edge equals the number of clocks since the previous horizontal leading edge, minus one. It saturates at its maximum.
- R5: h_err_o pulses with the horizontal sync report when h_win_lo <= pixel count < h_win_hi. A count equal to h_win_hi, or below h_win_lo, gives no error.
- R6: The line count checked at a vertical leading edge is the number of horizontal leading edges since the previous vertical leading edge. A horizontal edge in the same clock as a vertical edge is counted neither in the closing frame nor in the new one.
- R7: v_err_o pulses with the vertical sync report when v_win_lo <= line count < v_win_hi. A count equal to v_win_hi gives no error.
- R8: Both error outputs stay 0 until a vertical leading edge has been seen after reset. The edge that arms reporting cannot itself raise an error.
- R9: When horizontal and vertical leading edges coincide, both errors are judged in that same clock against the counts held before the edge. Both counters then restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| field_in | input | 1 | Odd/even field level, asynchronous |
| h_win_lo | input | CNT_W | First pixel count of the horizontal active window |
| h_win_hi | input | CNT_W | Pixel count just past the horizontal active window |
| v_win_lo | input | CNT_W | First line count of the vertical active window |
| v_win_hi | input | CNT_W | Line count just past the vertical active window |
| sync_seen_o | output | 1 | One-clock pulse on any sync leading edge |
| h_err_o | output | 1 | One-clock pulse: horizontal edge inside active window |
| v_err_o | output | 1 | One-clock pulse: vertical edge inside active window |
| odd_tgl_o | output | 1 | One-clock pulse on any field change |

## Verification
The horizontal and the vertical error judgement can fall in the same clock. This happens when both sync inputs rise together, and each judgement must then use its own pre-edge count while both counters restart.

The bench provokes this with a frame of three lines spaced eight clocks apart. It then raises both syncs at once, with windows chosen so that both counts land inside. It expects both error pulses together with a single sync report, and all outputs low one clock later.

A follow-up frame of one line then shows that the coinciding horizontal edge was dropped from the new line count.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;

  localparam int CMP_W = 16;

  typedef logic [CMP_W-1:0] cmp_t;

  typedef enum logic {
    EDGE_RISE,
    EDGE_ANY
  } edge_kind_e;

  // Half-open window test: lo <= pos < hi
  function automatic logic in_span(cmp_t pos, cmp_t lo, cmp_t hi);
    return (pos >= lo) && (pos < hi);
  endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int                      STAGES = 2,
  parameter sync_mon_pkg::edge_kind_e KIND  = sync_mon_pkg::EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic evt
);

  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  generate
    if (KIND == sync_mon_pkg::EDGE_RISE) begin : g_rise
      assign evt = chain[STAGES-1] & ~last;

      // R2
      rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
    end else begin : g_any
      assign evt = chain[STAGES-1] ^ last;
    end
  endgenerate

endmodule

// File: rtl/line_frame_cnt.sv
module line_frame_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_rise,
  input  logic             vs_rise,
  output logic [CNT_W-1:0] h_cnt,
  output logic [CNT_W-1:0] v_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)              h_cnt <= '0;
    else if (hs_rise)        h_cnt <= '0;
    else if (h_cnt != CNT_MAX) h_cnt <= h_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           v_cnt <= '0;
    else if (vs_rise)                     v_cnt <= '0;
    else if (hs_rise && v_cnt != CNT_MAX) v_cnt <= v_cnt + 1'b1;
  end

  // R4
  h_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> (h_cnt == '0));

  // R6
  v_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (v_cnt == '0));

endmodule

// File: rtl/sync_err_eval.sv
module sync_err_eval #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_rise,
  input  logic             vs_rise,
  input  logic             fld_chg,
  input  logic [CNT_W-1:0] h_cnt,
  input  logic [CNT_W-1:0] v_cnt,
  input  logic [CNT_W-1:0] h_lo,
  input  logic [CNT_W-1:0] h_hi,
  input  logic [CNT_W-1:0] v_lo,
  input  logic [CNT_W-1:0] v_hi,
  output logic             sync_seen_o,
  output logic             h_err_o,
  output logic             v_err_o,
  output logic             odd_tgl_o
);

  import sync_mon_pkg::*;

  logic armed;
  logic h_hit;
  logic v_hit;

  assign h_hit = hs_rise & armed & in_span(cmp_t'(h_cnt), cmp_t'(h_lo), cmp_t'(h_hi));
  assign v_hit = vs_rise & armed & in_span(cmp_t'(v_cnt), cmp_t'(v_lo), cmp_t'(v_hi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      sync_seen_o <= 1'b0;
      h_err_o     <= 1'b0;
      v_err_o     <= 1'b0;
      odd_tgl_o   <= 1'b0;
    end else begin
      if (vs_rise) armed <= 1'b1;
      sync_seen_o <= hs_rise | vs_rise;
      h_err_o     <= h_hit;
      v_err_o     <= v_hit;
      odd_tgl_o   <= fld_chg;
    end
  end

  // R8
  err_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_err_o || v_err_o) |-> $past(armed));

  // R5
  h_err_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_err_o |-> sync_seen_o);

  // R7
  v_err_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_err_o |-> sync_seen_o);

endmodule

// File: rtl/sync_err_mon.sv
module sync_err_mon #(
  parameter int CNT_W     = 12,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             field_in,
  input  logic [CNT_W-1:0] h_win_lo,
  input  logic [CNT_W-1:0] h_win_hi,
  input  logic [CNT_W-1:0] v_win_lo,
  input  logic [CNT_W-1:0] v_win_hi,
  output logic             sync_seen_o,
  output logic             h_err_o,
  output logic             v_err_o,
  output logic             odd_tgl_o
);

  logic             hs_rise;
  logic             vs_rise;
  logic             fld_chg;
  logic [CNT_W-1:0] h_cnt;
  logic [CNT_W-1:0] v_cnt;

  sync_edge_det #(.STAGES(SYNC_STGS), .KIND(sync_mon_pkg::EDGE_RISE)) u_hs_det (
    .clk(clk), .rst_n(rst_n), .din(hsync_in), .evt(hs_rise));

  sync_edge_det #(.STAGES(SYNC_STGS), .KIND(sync_mon_pkg::EDGE_RISE)) u_vs_det (
    .clk(clk), .rst_n(rst_n), .din(vsync_in), .evt(vs_rise));

  sync_edge_det #(.STAGES(SYNC_STGS), .KIND(sync_mon_pkg::EDGE_ANY)) u_fld_det (
    .clk(clk), .rst_n(rst_n), .din(field_in), .evt(fld_chg));

  line_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .h_cnt(h_cnt), .v_cnt(v_cnt));

  sync_err_eval #(.CNT_W(CNT_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .fld_chg(fld_chg), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .h_lo(h_win_lo), .h_hi(h_win_hi), .v_lo(v_win_lo), .v_hi(v_win_hi),
    .sync_seen_o(sync_seen_o), .h_err_o(h_err_o), .v_err_o(v_err_o),
    .odd_tgl_o(odd_tgl_o));

  // R3
  fld_not_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_chg && !hs_rise && !vs_rise) |=> (odd_tgl_o && !sync_seen_o));

endmodule

// File: tb/sync_err_mon_bench.sv
module sync_err_mon_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, hs, vs, fld;
  logic [11:0] hlo, hhi, vlo, vhi;
  logic        sync_seen, h_err, v_err, odd_tgl;

  sync_err_mon u_sync_err_mon (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs), .field_in(fld),
    .h_win_lo(hlo), .h_win_hi(hhi), .v_win_lo(vlo), .v_win_hi(vhi),
    .sync_seen_o(sync_seen), .h_err_o(h_err), .v_err_o(v_err), .odd_tgl_o(odd_tgl));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // {sync_seen, h_err, v_err, odd_tgl}
  logic [3:0] obs, obs2;

  // h table: window lo, window hi, period in clocks, expected h_err
  localparam int HV[7][4] = '{
    '{10, 20, 10, 0}, '{10, 20, 11, 1}, '{10, 20, 16, 1}, '{10, 20, 20, 1},
    '{10, 20, 21, 0}, '{ 0,  1,  5, 0}, '{ 4,  5,  5, 1}};

  // v table: window lo, window hi, lines, expected v_err
  localparam int VV[5][4] = '{
    '{3, 6, 2, 0}, '{3, 6, 3, 1}, '{3, 6, 5, 1}, '{3, 6, 6, 0}, '{0, 1, 0, 1}};

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; drives a one-clock pulse; samples the output
  // 3 negedges later (obs) and 4 negedges later (obs2).
  task automatic edge_go(logic dh, logic dv);
    hs = dh; vs = dv;
    @(negedge clk); hs = 1'b0; vs = 1'b0;
    @(negedge clk);
    @(negedge clk); obs  = {sync_seen, h_err, v_err, odd_tgl};
    @(negedge clk); obs2 = {sync_seen, h_err, v_err, odd_tgl};
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0; fld = 1'b0;
    hlo = 12'd10; hhi = 12'd20; vlo = 12'd0; vhi = 12'd100;
    gap(4);
    check("R1 outputs in reset", int'({sync_seen, h_err, v_err, odd_tgl}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", int'({sync_seen, h_err, v_err, odd_tgl}), 0);

    // R8: not armed yet, in-window period must not report
    edge_go(1, 0); gap(11);
    edge_go(1, 0);
    check("R8 h suppressed before arm", int'(obs[2]), 0);
    check("R2 sync pulse on hsync", int'(obs[3]), 1);
    check("R2 sync pulse one clock", int'(obs2[3]), 0);
    gap(2);
    edge_go(0, 1);
    check("R8 arming vsync gives no v_err", int'(obs[1]), 0);
    check("R2 sync pulse on vsync", int'(obs[3]), 1);

    // R4/R5 horizontal table
    foreach (HV[i]) begin
      gap(2);
      edge_go(1, 0);
      gap(HV[i][2] - 4);
      hlo = 12'(HV[i][0]); hhi = 12'(HV[i][1]);
      edge_go(1, 0);
      check($sformatf("R5 h_err period %0d", HV[i][2]), int'(obs[2]), HV[i][3]);
      check("R4 h_err single pulse", int'(obs2[2]), 0);
      check("R2 sync with h edge", int'(obs[3]), 1);
    end

    // R6/R7 vertical table
    foreach (VV[i]) begin
      gap(2);
      edge_go(0, 1); gap(2);
      for (int k = 0; k < VV[i][2]; k++) begin
        edge_go(1, 0); gap(2);
      end
      vlo = 12'(VV[i][0]); vhi = 12'(VV[i][1]);
      edge_go(0, 1);
      check($sformatf("R7 v_err lines %0d", VV[i][2]), int'(obs[1]), VV[i][3]);
      check("R6 v_err single pulse", int'(obs2[1]), 0);
    end

    // R9: coincident edges, both windows hit
    hlo = 12'd5; hhi = 12'd10; vlo = 12'd2; vhi = 12'd5;
    gap(2);
    edge_go(0, 1); gap(2);
    for (int k = 0; k < 3; k++) begin
      edge_go(1, 0); gap(4);
    end
    edge_go(1, 1);
    check("R9 h_err on coincident edge", int'(obs[2]), 1);
    check("R9 v_err on coincident edge", int'(obs[1]), 1);
    check("R2 single sync pulse coincident", int'(obs[3]), 1);
    check("R9 all low next clock", int'(obs2), 0);

    // R6: coincident hsync not counted in new frame
    gap(2);
    edge_go(1, 0); gap(2);
    vlo = 12'd1; vhi = 12'd2;
    edge_go(0, 1);
    check("R6 coincident hsync dropped", int'(obs[1]), 1);

    // R3: field toggles both ways
    gap(2);
    fld = 1'b1; gap(3);
    check("R3 odd on rise", int'(odd_tgl), 1);
    check("R3 no sync on field", int'(sync_seen), 0);
    gap(1);
    check("R3 odd single pulse", int'(odd_tgl), 0);
    fld = 1'b0; gap(3);
    check("R3 odd on fall", int'(odd_tgl), 1);
    gap(1);

    // R8 / R1: reset disarms again
    rst_n = 1'b0; gap(2); rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after second reset", int'({sync_seen, h_err, v_err, odd_tgl}), 0);
    vlo = 12'd0; vhi = 12'd100;
    edge_go(1, 0); gap(2);
    edge_go(0, 1);
    check("R8 disarmed after reset", int'(obs[1]), 0);
    check("R2 sync after reset", int'(obs[3]), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule